// File: doc/BRIEF.md
# Switch-Banked Static RAM Card

A byte-wide static RAM card for an 8-bit backplane. The address bus is `ADDR_W` bits wide. Its top three bits pick one of eight equal windows. The card holds one window's worth of bytes, `2^(ADDR_W-3)`. It answers only in the windows its eight switch inputs enable. The full-size card uses `ADDR_W = 16`, which gives 8 KiB windows over a 64 KiB space. The default build uses `ADDR_W = 14`, a 2 KiB card, so that it stays small and can be swept exhaustively.

The top three address bits go through a 3-to-8 decode. That one-hot term is ORed with the switch byte, and the card is selected when every bit of the result is 1. As a result:
- Pulling exactly one switch low maps the card into that window. A setting of 0xFB, for example, maps it into window 2.
- Leaving all switches high maps the card into every window, so its contents alias across the whole space.
- Pulling two or more switches low maps it nowhere.

Accesses never stall, and nothing handshakes at the bus edge. The `RETAIN` parameter selects between two variants:
- With `RETAIN = 0`, every reset is followed by a sequential clear that zeroes the store while `busy` is high.
- With `RETAIN = 1`, the contents ride through reset untouched, standing in for battery standby.

Top module: `bank_ram_card`

## Requirements
- R1: The card is selected for an address exactly when `bank_sw | (1 << addr[ADDR_W-1:ADDR_W-3])` equals 8'hFF. With a single switch bit `k` low, only window `k` responds.
- R2: With `bank_sw = 8'hFF`, every window is selected. Address `w*DEPTH + off` reaches the same byte `off` for all eight values of `w`, for both reads and writes.
- R3: With two or more bits of `bank_sw` low, no address selects the card. Reads return 8'h00.
- R4: When `rd_stb` is sampled high on an address that is not selected, or when `rd_stb` is low, `rdata` is 8'h00 after that clock edge.
- R5: A rising edge with `wr_stb` high, the card selected and `busy` low stores `wdata` at byte `addr[ADDR_W-4:0]`. A write to a window that is not selected leaves every byte unchanged.
- R6: A read sampled at a rising edge with `rd_stb` high, the card selected and `busy` low presents the stored byte on `rdata` right after that edge. There is no wait state and no handshake.
- R7: With `RETAIN = 0`, `busy` is high throughout reset and falls exactly `DEPTH + 2` cycles after `rst_n` is released. After that, every byte reads 8'h00.
- R8: With `RETAIN = 1`, `busy` never rises, and the stored bytes survive a reset pulse.
- R9: While `busy` is high, bus writes are ignored and reads return 8'h00.
- R10: While reset is asserted, `rdata` is 8'h00.
- R11: When a read and a write hit the same byte on the same edge, `rdata` shows the byte's previous contents. The new value is returned by a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Bus address; the top 3 bits pick the window |
| wdata | input | 8 | Write data |
| rd_stb | input | 1 | Memory-read strobe, active high |
| wr_stb | input | 1 | Memory-write strobe, active high |
| bank_sw | input | 8 | Switch bank, active low, one bit per window |
| rdata | output | 8 | Registered read data, 8'h00 when not driven by the store |
| busy | output | 1 | High while the post-reset clear runs (RETAIN = 0 only) |

## Verification
The store is filled through an ordinary one-hot setting, with part of the fill written through the all-open setting. Then all 256 switch values are crossed with all eight windows, using a different offset for each pair. This separates three cases: a correct one-hot decode (R1), the all-open aliasing (R2), and the multi-low settings that must never select (R3), including values such as 0xFC. Further directed sequences cover these behaviours:
- A write aimed at a disabled window must leave the enabled window intact.
- A read and a write on the same edge must expose the old byte.
- Reads issued during the clear must return zero.
Two instances, one built as each variant, then take a second reset. The retaining instance must still hold the written pattern, and the clearing instance must read back all zeros.

// File: rtl/bank_ram_pkg.sv
package bank_ram_pkg;
  localparam int DATA_W    = 8;
  localparam int BANK_BITS = 3;
  localparam int SW_W      = 1 << BANK_BITS;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [SW_W-1:0]   sw_t;
endpackage

// File: rtl/rc_reset_sync.sv
module rc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/rc_window_decode.sv
module rc_window_decode
  import bank_ram_pkg::*;
(
  input  logic [BANK_BITS-1:0] bank_idx,
  input  sw_t                  sw,
  output logic                 sel
);
  sw_t hit;

  // 3-to-8 one-hot decode of the window index
  for (genvar i = 0; i < SW_W; i++) begin : g_dec
    assign hit[i] = (bank_idx == BANK_BITS'(i));
  end

  // selected only when the active-low switch word fills in every other bit
  assign sel = &(sw | hit);
endmodule

// File: rtl/rc_clear_seq.sv
module rc_clear_seq #(
  parameter int OFF_W  = 11,
  parameter bit RETAIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy,
  output logic [OFF_W-1:0] clr_addr
);
  localparam logic             BUSY_AT_RESET = !RETAIN;
  localparam logic [OFF_W-1:0] LAST_ADDR     = '1;

  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_ADDR) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= BUSY_AT_RESET;
    end else begin
      if (busy_q) cnt_q <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy     = busy_q;
  assign clr_addr = cnt_q;

  // R7: the clear walks every byte in order, one per cycle
  assert_clear_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || clr_addr == $past(clr_addr) + 1'b1));

  // R7: the clear stops right after the last byte
  assert_clear_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clr_addr == LAST_ADDR) |=> !busy);
endmodule

// File: rtl/rc_byte_store.sv
module rc_byte_store
  import bank_ram_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             re,
  input  logic [OFF_W-1:0] addr,
  input  byte_t            wdata,
  output byte_t            rdata
);
  localparam int DEPTH = 1 << OFF_W;

  byte_t mem [DEPTH];
  byte_t rd_d;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_comb begin
    rd_d = re ? mem[addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_d;
  end
endmodule

// File: rtl/bank_ram_card.sv
module bank_ram_card
  import bank_ram_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter bit RETAIN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        bank_sw,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int OFF_W = ADDR_W - BANK_BITS;

  logic             rst_s_n;
  logic             sel;
  logic             bus_ok;
  logic             clr_busy;
  logic [OFF_W-1:0] clr_addr;
  logic [OFF_W-1:0] offset;
  logic             st_we, st_re;
  logic [OFF_W-1:0] st_addr;
  byte_t            st_wdata;

  rc_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  rc_window_decode u_dec (
    .bank_idx (addr[ADDR_W-1 -: BANK_BITS]),
    .sw       (bank_sw),
    .sel      (sel)
  );

  rc_clear_seq #(.OFF_W(OFF_W), .RETAIN(RETAIN)) u_clr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .busy     (clr_busy),
    .clr_addr (clr_addr)
  );

  assign offset = addr[OFF_W-1:0];
  assign bus_ok = sel & ~clr_busy;

  // the clear owns the store port while it runs
  always_comb begin
    if (clr_busy) begin
      st_we    = 1'b1;
      st_re    = 1'b0;
      st_addr  = clr_addr;
      st_wdata = '0;
    end else begin
      st_we    = wr_stb & bus_ok;
      st_re    = rd_stb & bus_ok;
      st_addr  = offset;
      st_wdata = wdata;
    end
  end

  rc_byte_store #(.OFF_W(OFF_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (st_we),
    .re    (st_re),
    .addr  (st_addr),
    .wdata (st_wdata),
    .rdata (rdata)
  );

  assign busy = clr_busy;

  // R3: a switch word with two or more low bits never selects
  assert_multi_low_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($countones(~bank_sw) > 1) |-> !sel);

  // R4: unselected reads return zero on the next cycle
  assert_oob_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_stb && !sel) |=> (rdata == 8'h00));

  // R4: no read strobe means zero read data
  assert_idle_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rd_stb |=> (rdata == 8'h00));

  // R9: the bus sees nothing while the clear runs
  assert_busy_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy |=> (rdata == 8'h00));
endmodule

// File: tb/bank_ram_card_test.sv
`timescale 1ns/1ps
module bank_ram_card_test;
  localparam int ADDR_W = 14;
  localparam int OFF_W  = ADDR_W - 3;
  localparam int DEPTH  = 1 << OFF_W;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata;
  logic              rd_stb, wr_stb;
  logic [7:0]        bank_sw;
  logic [7:0]        rdata, rdata_k;
  logic              busy, busy_k;

  int checks = 0;
  int fails  = 0;
  bit reported = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  bank_ram_card #(.ADDR_W(ADDR_W), .RETAIN(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .bank_sw(bank_sw), .rdata(rdata), .busy(busy));

  bank_ram_card #(.ADDR_W(ADDR_W), .RETAIN(1'b1)) uut_keep (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .bank_sw(bank_sw), .rdata(rdata_k), .busy(busy_k));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [7:0] pat(input int off);
    return 8'((off * 7 + 3) ^ (off >> 8));
  endfunction

  function automatic bit sel_exp(input int sw, input int w);
    return ((sw | (1 << w)) & 255) == 255;
  endfunction

  task automatic bus_read(input int a, input int sw,
                          output logic [7:0] d0, output logic [7:0] d1);
    @(negedge clk);
    addr = ADDR_W'(a); bank_sw = 8'(sw); rd_stb = 1'b1; wr_stb = 1'b0;
    @(negedge clk);
    d0 = rdata; d1 = rdata_k;
    rd_stb = 1'b0;
  endtask

  task automatic bus_write(input int a, input int sw, input int d);
    @(negedge clk);
    addr = ADDR_W'(a); bank_sw = 8'(sw); wdata = 8'(d); wr_stb = 1'b1; rd_stb = 1'b0;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // pulse reset, return cycles until uut clear ends and whether uut_keep ever went busy
  task automatic do_reset(output int cyc, output int keep_busy);
    @(negedge clk);
    rst_n = 1'b0; rd_stb = 1'b1; addr = '0; bank_sw = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R10 rdata in reset", int'(rdata), 0);
    chk("R10 rdata_keep in reset", int'(rdata_k), 0);
    chk("R7 busy in reset", int'(busy), 1);
    chk("R8 keep not busy in reset", int'(busy_k), 0);
    rd_stb = 1'b0;
    rst_n = 1'b1;
    cyc = 0; keep_busy = 0;
    while (busy && cyc < DEPTH + 50) begin
      @(negedge clk);
      cyc++;
      if (busy_k) keep_busy = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    logic [7:0] d0, d1;
    int cyc, kb;
    rst_n = 1'b0; addr = '0; wdata = '0; rd_stb = 1'b0; wr_stb = 1'b0; bank_sw = 8'hFB;

    // first reset; probe the bus while the clear runs (R9)
    @(negedge clk);
    @(negedge clk);
    chk("R10 rdata at reset", int'(rdata), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 busy during clear", int'(busy), 1);
    bus_write(DEPTH - 1, 8'hFE, 8'hA5);
    bus_read(DEPTH - 1, 8'hFE, d0, d1);
    chk("R9 read during clear", int'(d0), 0);
    while (busy) @(negedge clk);

    // second reset for exact timing
    do_reset(cyc, kb);
    chk("R7 clear length", cyc, DEPTH + 2);
    chk("R8 keep never busy", kb, 0);

    // R7: every byte zero after clear
    begin
      int bad = 0;
      for (int off = 0; off < DEPTH; off++) begin
        bus_read(off, 8'hFE, d0, d1);
        if (d0 != 8'h00) bad++;
      end
      chk("R7 zeroed bytes nonzero count", bad, 0);
    end

    // fill: even offsets through window 2 (0xFB), odd ones through all-open aliasing (R2)
    for (int off = 0; off < DEPTH; off++) begin
      if (off % 2 == 0) bus_write(2 * DEPTH + off, 8'hFB, pat(off));
      else              bus_write(((off / 2) % 8) * DEPTH + off, 8'hFF, pat(off));
    end

    // R6: latency - zero before the edge, data after it
    @(negedge clk);
    addr = ADDR_W'(2 * DEPTH + 17); bank_sw = 8'hFB; rd_stb = 1'b1;
    #0.5;
    chk("R6 before edge", int'(rdata), 0);
    @(negedge clk);
    chk("R6 after one edge", int'(rdata), int'(pat(17)));
    rd_stb = 1'b0;
    @(negedge clk);
    chk("R4 strobe low", int'(rdata), 0);

    // decode sweep: every switch value x every window
    for (int sw = 0; sw < 256; sw++) begin
      for (int w = 0; w < 8; w++) begin
        int off;
        int exp;
        string tag;
        off = (sw * 37 + w * 301) % DEPTH;
        exp = sel_exp(sw, w) ? int'(pat(off)) : 0;
        if (sw == 255) tag = "R2 all-open alias";
        else if ($countones(8'(~sw)) > 1) tag = "R3 multi-low never selects";
        else if (sel_exp(sw, w)) tag = "R1 one-hot window hit";
        else tag = "R4 out-of-window read";
        bus_read(w * DEPTH + off, sw, d0, d1);
        chk(tag, int'(d0), exp);
        chk({tag, " keep"}, int'(d1), exp);
      end
    end

    // R5: write to disabled window changes nothing
    bus_write(5 * DEPTH + 9, 8'hFB, 8'h11);
    bus_read(2 * DEPTH + 9, 8'hFB, d0, d1);
    chk("R5 oob write ignored", int'(d0), int'(pat(9)));
    bus_write(2 * DEPTH + 9, 8'h7F, 8'h22);
    bus_read(2 * DEPTH + 9, 8'hFB, d0, d1);
    chk("R5 oob write ignored 0x7F", int'(d0), int'(pat(9)));

    // R11: same-edge read and write
    @(negedge clk);
    addr = ADDR_W'(2 * DEPTH + 5); bank_sw = 8'hFB; wdata = 8'h3C;
    rd_stb = 1'b1; wr_stb = 1'b1;
    @(negedge clk);
    chk("R11 old data on collision", int'(rdata), int'(pat(5)));
    rd_stb = 1'b0; wr_stb = 1'b0;
    bus_read(2 * DEPTH + 5, 8'hFB, d0, d1);
    chk("R11 new data later", int'(d0), 8'h3C);
    chk("R5 write stored", int'(d1), 8'h3C);
    bus_write(2 * DEPTH + 5, 8'hFB, pat(5));

    // retention across reset
    do_reset(cyc, kb);
    chk("R7 clear length again", cyc, DEPTH + 2);
    chk("R8 keep never busy again", kb, 0);
    begin
      int bad_k = 0;
      int bad_z = 0;
      for (int off = 0; off < DEPTH; off++) begin
        bus_read(2 * DEPTH + off, 8'hFB, d0, d1);
        if (d1 != pat(off)) bad_k++;
        if (d0 != 8'h00) bad_z++;
      end
      chk("R8 retained mismatch count", bad_k, 0);
      chk("R7 cleared nonzero count", bad_z, 0);
    end

    report();
  end
endmodule